// File: doc/BRIEF.md
# Dual-Channel PWM Timer with Selectable Resolution

One counter drives two pulse-width-modulated outputs, A and B. Each output has its own compare register. The counter width is selected at run time as 8, 9 or 10 bits. It runs in one of two modes:

- **Symmetric (dual-slope) mode:** the counter climbs from zero to TOP and then descends back to zero.
- **Single-slope mode:** the counter climbs from zero to TOP and then wraps to zero. Its period is about half that of the dual-slope mode at the same resolution.

Each compare value is double-buffered, so the duty cycle can be changed at any moment without a partial or glitched pulse. Each channel has a 2-bit output-mode field. It either holds the pin low or drives the waveform in true or inverted polarity.

Software writes the counter and the compare registers through one shared data bus and three write strobes. The bits above the selected resolution are cleared by the hardware. This happens both on a write and when the resolution is narrowed, so a read-modify-write never leaves stale upper bits behind.

Top module: `pwm_dual_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, the counter reads 0 and then 1, the direction flag reads 0 (counting up), both compare readbacks read 0 and both outputs are low.
- R2: `res_sel_i` selects TOP: 00 gives 0x00FF, 01 gives 0x01FF, and 10 or 11 give 0x03FF. The counter and both compare readbacks never exceed TOP. Bits above TOP are zeroed on a write and also when a narrower resolution is selected, so they stay zero after the resolution is widened again.
- R3: With `fast_mode_i` = 0 the counter steps by one. At TOP (flag 0) it turns to TOP-1 and sets `count_down_o` to 1. At 0 (flag 1) it turns to 1 and clears the flag.
- R4: With `fast_mode_i` = 1 the counter steps 0, 1, …, TOP and then 0 again, and `count_down_o` is 0.
- R5: `cnt_we_i` loads `wdata_i` masked to TOP, visible in the next cycle, in place of the count step. In dual-slope mode the direction flag is kept. A compare strobe makes the masked value visible on the readback in the next cycle.
- R6: A written compare value governs its output only from the cycle after the counter shows TOP. Until then the previous value stays in force.
- R7: The output-mode field works as follows. 00 and 01 hold the output low. 10 drives the waveform level. 11 drives its inverse. A change of the field shows on the output in the same cycle.
- R8: In dual-slope mode, let C be an active compare value with 0 < C < TOP. The level drops one cycle after the counter equals C while rising, and rises one cycle after it equals C while falling. This gives 2·C high cycles per 2·TOP-cycle period.
- R9: In single-slope mode, let C be an active compare value with 0 < C < TOP. The level rises in the cycle the counter shows 0 after a wrap and drops one cycle after the counter equals C. This gives C+1 high cycles per (TOP+1)-cycle period.
- R10: In both modes, an active compare value of 0 holds the level constantly low and a value of TOP holds it constantly high, with no one-cycle pulses.
- R11: Both channels share the counter but work independently: their compare values and output modes do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_sel_i | input | 2 | Resolution select (8/9/10 bits) |
| fast_mode_i | input | 1 | 1 = single-slope mode, 0 = dual-slope mode |
| com_a_i | input | 2 | Output mode of channel A |
| com_b_i | input | 2 | Output mode of channel B |
| cnt_we_i | input | 1 | Counter write strobe |
| cmp_a_we_i | input | 1 | Compare A write strobe |
| cmp_b_we_i | input | 1 | Compare B write strobe |
| wdata_i | input | 16 | Shared write data |
| cnt_o | output | 16 | Counter value, masked to TOP |
| count_down_o | output | 1 | Counting direction, 1 = descending |
| cmp_a_o | output | 16 | Compare A readback (buffered value) |
| cmp_b_o | output | 16 | Compare B readback (buffered value) |
| pwm_a_o | output | 1 | Channel A waveform |
| pwm_b_o | output | 1 | Channel B waveform |

## Verification
The waveform is measured as a count of high cycles over one full period, for compare values inside the range and at 0 and TOP. This is done in both counting modes, in all output modes and at each resolution, which separates the dual-slope 2·C law from the single-slope C+1 law and exposes any spike at the ends of the range. Directed sequences step the counter across both turn points and the wrap, and load it while it descends. A compare value is rewritten mid-period to show that the old value still rules until TOP. Long random stretches then change resolution, mode, output modes and register writes at unrelated moments, and a reference model is compared against every output each cycle; these stretches catch masking and reload errors that only appear when such events coincide.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;

    // Register width seen on the write bus and the readbacks.
    localparam int unsigned CNT_W     = 16;
    // Narrowest resolution and number of selectable steps above it.
    localparam int unsigned RES_MIN   = 8;
    localparam int unsigned RES_STEPS = 3;
    localparam int unsigned RES_SEL_W = 2;
    localparam int unsigned NUM_CH    = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        COM_OFF  = 2'b00,
        COM_RSVD = 2'b01,
        COM_NORM = 2'b10,
        COM_INV  = 2'b11
    } com_e;

    // TOP (all ones of the selected resolution); codes past the last step saturate.
    function automatic cnt_t top_for(input logic [RES_SEL_W-1:0] sel);
        logic [31:0] step;
        step = 32'(sel);
        if (step > RES_STEPS - 1) begin
            step = RES_STEPS - 1;
        end
        return cnt_t'((32'd1 << (RES_MIN + step)) - 32'd1);
    endfunction

endpackage

// File: rtl/pwm_updown_counter.sv
`timescale 1ns/1ps
module pwm_updown_counter
    import pwm_timer_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  cnt_t top_i,
    input  logic fast_i,
    input  logic we_i,
    input  cnt_t wdata_i,
    output cnt_t cnt_o,
    output logic down_o
);

    typedef struct packed {
        cnt_t cnt;
        logic down;
    } ctr_state_t;

    ctr_state_t ctr_d, ctr_q;
    cnt_t       cnt_m;

    // Stored value cut to the current resolution (covers a narrowing switch).
    assign cnt_m = ctr_q.cnt & top_i;

    always_comb begin
        ctr_d     = ctr_q;
        ctr_d.cnt = cnt_m;
        if (we_i) begin
            ctr_d.cnt  = wdata_i & top_i;
            ctr_d.down = fast_i ? 1'b0 : ctr_q.down;
        end else if (fast_i) begin
            ctr_d.down = 1'b0;
            ctr_d.cnt  = (cnt_m == top_i) ? '0 : cnt_m + cnt_t'(1);
        end else if (!ctr_q.down) begin
            if (cnt_m == top_i) begin
                ctr_d.down = 1'b1;
                ctr_d.cnt  = top_i - cnt_t'(1);
            end else begin
                ctr_d.cnt  = cnt_m + cnt_t'(1);
            end
        end else begin
            if (cnt_m == '0) begin
                ctr_d.down = 1'b0;
                ctr_d.cnt  = cnt_t'(1);
            end else begin
                ctr_d.cnt  = cnt_m - cnt_t'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt_o  = cnt_m;
    assign down_o = ctr_q.down;

endmodule

// File: rtl/pwm_compare_channel.sv
`timescale 1ns/1ps
module pwm_compare_channel
    import pwm_timer_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  cnt_t       top_i,
    input  cnt_t       cnt_i,
    input  logic       down_i,
    input  logic       fast_i,
    input  logic [1:0] com_i,
    input  logic       we_i,
    input  cnt_t       wdata_i,
    output cnt_t       cmp_o,
    output logic       pwm_o
);

    typedef struct packed {
        cnt_t shadow;  // value written by software
        cnt_t act;     // value the comparator uses
        logic lvl;     // non-inverted waveform level
    } ch_state_t;

    ch_state_t ch_d, ch_q;
    cnt_t      act_m;
    logic      at_top;

    assign act_m  = ch_q.act & top_i;
    assign at_top = (cnt_i == top_i);

    always_comb begin
        ch_d        = ch_q;
        ch_d.shadow = (we_i ? wdata_i : ch_q.shadow) & top_i;
        // Reload only at the turn point so a period never mixes two values.
        ch_d.act    = at_top ? (ch_q.shadow & top_i) : act_m;

        if (act_m == '0) begin
            ch_d.lvl = 1'b0;
        end else if (act_m == top_i) begin
            ch_d.lvl = 1'b1;
        end else if (cnt_i == act_m) begin
            ch_d.lvl = fast_i ? 1'b0 : down_i;
        end else if (fast_i && at_top) begin
            ch_d.lvl = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    always_comb begin
        unique case (com_e'(com_i))
            COM_NORM: pwm_o = ch_q.lvl;
            COM_INV:  pwm_o = ~ch_q.lvl;
            default:  pwm_o = 1'b0;
        endcase
    end

    assign cmp_o = ch_q.shadow & top_i;

endmodule

// File: rtl/pwm_dual_timer.sv
`timescale 1ns/1ps
module pwm_dual_timer
    import pwm_timer_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [RES_SEL_W-1:0] res_sel_i,
    input  logic                 fast_mode_i,
    input  logic [1:0]           com_a_i,
    input  logic [1:0]           com_b_i,
    input  logic                 cnt_we_i,
    input  logic                 cmp_a_we_i,
    input  logic                 cmp_b_we_i,
    input  logic [CNT_W-1:0]     wdata_i,
    output logic [CNT_W-1:0]     cnt_o,
    output logic                 count_down_o,
    output logic [CNT_W-1:0]     cmp_a_o,
    output logic [CNT_W-1:0]     cmp_b_o,
    output logic                 pwm_a_o,
    output logic                 pwm_b_o
);

    cnt_t       top_w;
    cnt_t       cnt_w;
    logic       down_w;
    logic [1:0] com_v [NUM_CH];
    logic       we_v  [NUM_CH];
    cnt_t       cmp_v [NUM_CH];
    logic       pwm_v [NUM_CH];

    assign top_w = top_for(res_sel_i);

    assign com_v[0] = com_a_i;
    assign com_v[1] = com_b_i;
    assign we_v[0]  = cmp_a_we_i;
    assign we_v[1]  = cmp_b_we_i;

    pwm_updown_counter i_counter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .top_i   (top_w),
        .fast_i  (fast_mode_i),
        .we_i    (cnt_we_i),
        .wdata_i (wdata_i),
        .cnt_o   (cnt_w),
        .down_o  (down_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_compare_channel i_channel (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .top_i   (top_w),
            .cnt_i   (cnt_w),
            .down_i  (down_w),
            .fast_i  (fast_mode_i),
            .com_i   (com_v[g]),
            .we_i    (we_v[g]),
            .wdata_i (wdata_i),
            .cmp_o   (cmp_v[g]),
            .pwm_o   (pwm_v[g])
        );
    end

    assign cnt_o        = cnt_w;
    assign count_down_o = down_w;
    assign cmp_a_o      = cmp_v[0];
    assign cmp_b_o      = cmp_v[1];
    assign pwm_a_o      = pwm_v[0];
    assign pwm_b_o      = pwm_v[1];

endmodule

// File: rtl/pwm_dual_timer_chk.sv
`timescale 1ns/1ps
module pwm_dual_timer_chk
    import pwm_timer_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [RES_SEL_W-1:0] res_sel_i,
    input logic                 fast_mode_i,
    input logic [1:0]           com_a_i,
    input logic [1:0]           com_b_i,
    input logic                 cnt_we_i,
    input logic [CNT_W-1:0]     cnt_o,
    input logic                 count_down_o,
    input logic [CNT_W-1:0]     cmp_a_o,
    input logic [CNT_W-1:0]     cmp_b_o,
    input logic                 pwm_a_o,
    input logic                 pwm_b_o
);

    cnt_t top_c;
    assign top_c = top_for(res_sel_i);

    // R2
    cnt_within_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_o <= top_c);

    // R2
    cmp_within_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_a_o <= top_c) && (cmp_b_o <= top_c));

    // R3
    dual_slope_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fast_mode_i && !cnt_we_i) |=>
            (res_sel_i != $past(res_sel_i)) ||
            (cnt_o == $past(cnt_o) + 16'd1) ||
            (cnt_o == $past(cnt_o) - 16'd1));

    // R4
    single_slope_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fast_mode_i && !cnt_we_i) |=>
            (res_sel_i != $past(res_sel_i)) ||
            (cnt_o == $past(cnt_o) + 16'd1) ||
            (cnt_o == '0));

    // R4
    single_slope_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fast_mode_i && $past(fast_mode_i)) |-> !count_down_o);

    // R7
    pin_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!com_a_i[1] |-> !pwm_a_o) and (!com_b_i[1] |-> !pwm_b_o));

endmodule

bind pwm_dual_timer pwm_dual_timer_chk i_pwm_dual_timer_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .res_sel_i    (res_sel_i),
    .fast_mode_i  (fast_mode_i),
    .com_a_i      (com_a_i),
    .com_b_i      (com_b_i),
    .cnt_we_i     (cnt_we_i),
    .cnt_o        (cnt_o),
    .count_down_o (count_down_o),
    .cmp_a_o      (cmp_a_o),
    .cmp_b_o      (cmp_b_o),
    .pwm_a_o      (pwm_a_o),
    .pwm_b_o      (pwm_b_o)
);

// File: tb/test_pwm_dual_timer.sv
`timescale 1ns/1ps
module test_pwm_dual_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  res_sel = 2'b00;
    logic        fast = 1'b0;
    logic [1:0]  com_a = 2'b00;
    logic [1:0]  com_b = 2'b00;
    logic        cnt_we = 1'b0;
    logic        cmp_a_we = 1'b0;
    logic        cmp_b_we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] cnt_o, cmp_a_o, cmp_b_o;
    logic        count_down_o, pwm_a_o, pwm_b_o;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwm_dual_timer i_pwm_dual_timer (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .res_sel_i    (res_sel),
        .fast_mode_i  (fast),
        .com_a_i      (com_a),
        .com_b_i      (com_b),
        .cnt_we_i     (cnt_we),
        .cmp_a_we_i   (cmp_a_we),
        .cmp_b_we_i   (cmp_b_we),
        .wdata_i      (wdata),
        .cnt_o        (cnt_o),
        .count_down_o (count_down_o),
        .cmp_a_o      (cmp_a_o),
        .cmp_b_o      (cmp_b_o),
        .pwm_a_o      (pwm_a_o),
        .pwm_b_o      (pwm_b_o)
    );

    // ---------------- expectations from the requirements ----------------
    function automatic logic [15:0] f_top(input logic [1:0] s);
        case (s)
            2'b00:   return 16'h00FF;
            2'b01:   return 16'h01FF;
            default: return 16'h03FF;
        endcase
    endfunction

    function automatic logic f_pin(input logic [1:0] com, input logic lvl);
        if (com == 2'b10) return lvl;
        if (com == 2'b11) return ~lvl;
        return 1'b0;
    endfunction

    function automatic int exp_high(input logic fm, input int c, input int t,
                                    input logic [1:0] com, input int per);
        int base;
        if (c == 0)      base = 0;
        else if (c >= t) base = per;
        else if (fm)     base = c + 1;
        else             base = 2 * c;
        if (com == 2'b11) return per - base;
        if (com == 2'b10) return base;
        return 0;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Cycle model: per-cycle state derived from R2..R10.
    logic [15:0] m_cnt;
    logic        m_down;
    logic [15:0] m_sh  [2];
    logic [15:0] m_act [2];
    logic        m_lvl [2];

    always @(posedge clk or negedge rst_n) begin : model_blk
        logic [15:0] t, cm, am;
        logic        wr;
        if (!rst_n) begin
            m_cnt  <= '0;
            m_down <= 1'b0;
            for (int k = 0; k < 2; k++) begin
                m_sh[k]  <= '0;
                m_act[k] <= '0;
                m_lvl[k] <= 1'b0;
            end
        end else begin
            t  = f_top(res_sel);
            cm = m_cnt & t;
            for (int k = 0; k < 2; k++) begin
                am = m_act[k] & t;
                wr = (k == 0) ? cmp_a_we : cmp_b_we;
                m_sh[k]  <= (wr ? wdata : m_sh[k]) & t;
                m_act[k] <= (cm == t) ? (m_sh[k] & t) : am;
                if (am == 16'd0)                 m_lvl[k] <= 1'b0;
                else if (am == t)                m_lvl[k] <= 1'b1;
                else if (cm == am)               m_lvl[k] <= fast ? 1'b0 : m_down;
                else if (fast && cm == t)        m_lvl[k] <= 1'b1;
            end
            if (cnt_we) begin
                m_cnt  <= wdata & t;
                m_down <= fast ? 1'b0 : m_down;
            end else if (fast) begin
                m_down <= 1'b0;
                m_cnt  <= (cm == t) ? 16'd0 : cm + 16'd1;
            end else if (!m_down) begin
                if (cm == t) begin m_down <= 1'b1; m_cnt <= t - 16'd1; end
                else         m_cnt <= cm + 16'd1;
            end else begin
                if (cm == 16'd0) begin m_down <= 1'b0; m_cnt <= 16'd1; end
                else             m_cnt <= cm - 16'd1;
            end
        end
    end

    // Every-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && chk_en && !done) begin
            check(fast ? "R4" : "R3", "counter", 32'(cnt_o), 32'(m_cnt & f_top(res_sel)));
            check(fast ? "R4" : "R3", "direction", 32'(count_down_o), 32'(m_down));
            check("R5", "readback A", 32'(cmp_a_o), 32'(m_sh[0] & f_top(res_sel)));
            check("R5", "readback B", 32'(cmp_b_o), 32'(m_sh[1] & f_top(res_sel)));
            check(fast ? "R9" : "R8", "pin A", 32'(pwm_a_o), 32'(f_pin(com_a, m_lvl[0])));
            check(fast ? "R9" : "R8", "pin B", 32'(pwm_b_o), 32'(f_pin(com_b, m_lvl[1])));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        cnt_we = 1'b1; wdata = v; tick(); cnt_we = 1'b0;
    endtask

    task automatic wr_cmp(input int ch, input logic [15:0] v);
        if (ch == 0) cmp_a_we = 1'b1; else cmp_b_we = 1'b1;
        wdata = v; tick();
        cmp_a_we = 1'b0; cmp_b_we = 1'b0;
    endtask

    task automatic expect_step(input string tag, input logic [15:0] c, input logic dn);
        check(tag, "count", 32'(cnt_o), 32'(c));
        check(tag, "dir", 32'(count_down_o), 32'(dn));
    endtask

    task automatic duty(input logic [1:0] res, input logic fm, input int ca, input int cb,
                        input logic [1:0] coma, input logic [1:0] comb,
                        input string tag_a, input string tag_b);
        int t, per, ha, hb;
        t   = int'(f_top(res));
        per = fm ? t + 1 : 2 * t;
        res_sel = res; fast = fm; com_a = coma; com_b = comb;
        wr_cmp(0, 16'(ca));
        wr_cmp(1, 16'(cb));
        repeat (3 * per) tick();
        ha = 0; hb = 0;
        repeat (per) begin
            @(negedge clk);
            ha += int'(pwm_a_o);
            hb += int'(pwm_b_o);
        end
        #1;
        check(tag_a, "high cycles A", 32'(ha), 32'(exp_high(fm, ca, t, coma, per)));
        check(tag_b, "high cycles B", 32'(hb), 32'(exp_high(fm, cb, t, comb, per)));
    endtask

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: state under reset
        check("R1", "count in reset", 32'(cnt_o), 32'd0);
        check("R1", "dir in reset", 32'(count_down_o), 32'd0);
        check("R1", "readback A in reset", 32'(cmp_a_o), 32'd0);
        check("R1", "readback B in reset", 32'(cmp_b_o), 32'd0);
        check("R1", "pins in reset", 32'({pwm_a_o, pwm_b_o}), 32'd0);
        #1 rst_n = 1'b1;
        chk_en = 1'b1;
        tick();
        check("R1", "first count", 32'(cnt_o), 32'd1);
        check("R1", "first dir", 32'(count_down_o), 32'd0);

        // R2: masking on write and on narrowing
        wr_cnt(16'hFFFF);
        check("R2", "8-bit counter write", 32'(cnt_o), 32'h00FF);
        res_sel = 2'b01;
        wr_cmp(0, 16'hFFFF);
        check("R2", "9-bit compare write", 32'(cmp_a_o), 32'h01FF);
        res_sel = 2'b00;
        tick();
        check("R2", "narrowed readback", 32'(cmp_a_o), 32'h00FF);
        res_sel = 2'b10;
        tick();
        check("R2", "bit stays cleared after widening", 32'(cmp_a_o), 32'h00FF);
        wr_cmp(1, 16'hF3A5);
        check("R2", "10-bit compare write", 32'(cmp_b_o), 32'h03A5);

        // R3: dual-slope turning points
        res_sel = 2'b00; fast = 1'b0;
        wr_cnt(16'd253);  expect_step("R5", 16'd253, 1'b0);
        tick();           expect_step("R3", 16'd254, 1'b0);
        tick();           expect_step("R3", 16'd255, 1'b0);
        tick();           expect_step("R3", 16'd254, 1'b1);
        wr_cnt(16'd2);    expect_step("R5", 16'd2, 1'b1);
        tick();           expect_step("R3", 16'd1, 1'b1);
        tick();           expect_step("R3", 16'd0, 1'b1);
        tick();           expect_step("R3", 16'd1, 1'b0);

        // R4: single-slope wrap
        fast = 1'b1;
        wr_cnt(16'd254);  expect_step("R4", 16'd254, 1'b0);
        tick();           expect_step("R4", 16'd255, 1'b0);
        tick();           expect_step("R4", 16'd0, 1'b0);
        tick();           expect_step("R4", 16'd1, 1'b0);

        // Waveform duty across modes, output modes and resolutions
        duty(2'b00, 1'b0, 64, 200, 2'b10, 2'b10, "R8", "R11");
        duty(2'b00, 1'b0, 64, 64, 2'b10, 2'b11, "R8", "R7");
        duty(2'b00, 1'b0, 0, 255, 2'b10, 2'b10, "R10", "R10");
        duty(2'b00, 1'b1, 64, 1, 2'b10, 2'b10, "R9", "R11");
        duty(2'b00, 1'b1, 0, 255, 2'b10, 2'b11, "R10", "R10");
        duty(2'b01, 1'b0, 300, 100, 2'b10, 2'b00, "R8", "R7");
        duty(2'b00, 1'b1, 128, 128, 2'b01, 2'b11, "R7", "R7");
        duty(2'b10, 1'b1, 700, 5, 2'b10, 2'b10, "R9", "R11");

        // R6: a rewrite mid-period waits for TOP
        res_sel = 2'b00; fast = 1'b1; com_a = 2'b10;
        wr_cmp(0, 16'd100);
        repeat (600) tick();
        while (cnt_o != 16'd5) tick();
        wr_cmp(0, 16'd20);
        check("R5", "readback after rewrite", 32'(cmp_a_o), 32'd20);
        while (cnt_o != 16'd50) tick();
        check("R6", "old compare still rules", 32'(pwm_a_o), 32'd1);
        while (cnt_o != 16'd0) tick();
        while (cnt_o != 16'd50) tick();
        check("R6", "new compare after TOP", 32'(pwm_a_o), 32'd0);

        // Random phase: rare changes so full sweeps happen between them
        for (int i = 0; i < 20000; i++) begin
            int r;
            logic [15:0] v;
            r = int'($urandom % 256);
            v = ($urandom % 4 == 0) ? (($urandom % 2 == 0) ? 16'h0000 : 16'hFFFF)
                                    : 16'($urandom);
            case (r)
                0:  res_sel = 2'($urandom);
                1:  fast    = 1'($urandom);
                2:  com_a   = 2'($urandom);
                3:  com_b   = 2'($urandom);
                4:  begin cnt_we = 1'b1; wdata = v; end
                5, 6, 7, 8:   begin cmp_a_we = 1'b1; wdata = v; end
                9, 10, 11, 12: begin cmp_b_we = 1'b1; wdata = v; end
                13: begin cmp_a_we = 1'b1; cmp_b_we = 1'b1; wdata = v; end
                default: ;
            endcase
            tick();
            cnt_we = 1'b0; cmp_a_we = 1'b0; cmp_b_we = 1'b0;
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule